// File: doc/BRIEF.md
# Variable Block Size SAD Search Engine

This engine runs the integer-pixel matching stage of a block-based motion search. For every candidate displacement it receives the sixteen 4×4 sub-blocks of a 16×16 current macroblock together with the matching sub-blocks of the displaced reference. It takes them one per clock cycle in raster order. One 4×4 sum-of-absolute-differences unit is the only arithmetic element that touches pixels. The sixteen small results of a candidate are then added into the costs of all seven partition shapes: 16×16, 16×8, 8×16, 8×8, 8×4, 4×8 and 4×4. That gives 41 partition costs per candidate.

For each of the 41 partitions the block keeps the lowest cost seen since the last start pulse, with the displacement that produced it. A search is one start pulse followed by any number of candidates sent back to back. The last block of the last candidate is flagged, and a one-cycle done pulse shows that the 41 minima and their vectors are final. The caller walks the ±16 window in its chosen scan order and owns the reference memory.

Top module: `vbs_sad_search`

## Requirements
- R1: Pixels are 8-bit unsigned. On `cur_blk` and `ref_blk`, the pixel in row i, column j of a 4×4 block sits at bits [(4*i+j)*8 +: 8]. The 4×4 partition costs (indices 25..40) are the plain SAD of those 16 pixel pairs.
- R2: The sixteen 4×4 blocks of one candidate arrive in raster order: block b covers macroblock rows 4*(b/4)..+3 and columns 4*(b%4)..+3. 4×4 partition index 25+b refers to block b.
- R3: Partition index 0 is the 16×16 cost, the sum of all sixteen block SADs, held in 16 bits.
- R4: Indices 1..2 are the top and bottom 16×8 halves. Indices 3..4 are the left and right 8×16 halves.
- R5: Indices 5..8 are the 8×8 quadrants in raster order. For quadrant q, indices 9+2q and 10+2q are its upper and lower 8×4 halves, and indices 17+2q and 18+2q are its left and right 4×8 halves.
- R6: A partition's stored best changes only when a new cost is strictly lower. On a tie the earlier candidate's cost and vector stay.
- R7: A start pulse, and reset, sets every best cost to 16'hFFFF and every best vector to (0,0).
- R8: `done` goes high for exactly one cycle, two clock edges after the edge that accepts the flagged last block. In that cycle all 41 results include the last candidate.
- R9: Blocks are accepted on every cycle with `blk_valid` high, so candidates can follow each other with no idle cycles.
- R10: Displacements are 6-bit two's complement (range −16..+16 used), taken with block 15 of each candidate and reported unchanged with the winning cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a new search, clears all best values |
| blk_valid | input | 1 | A 4×4 block pair is present |
| blk_last | input | 1 | Marks block 15 of the final candidate |
| mv_x | input | 6 | Horizontal displacement of the candidate, signed |
| mv_y | input | 6 | Vertical displacement of the candidate, signed |
| cur_blk | input | 128 | Current 4×4 block, 16 packed pixels |
| ref_blk | input | 128 | Reference 4×4 block, 16 packed pixels |
| best_cost | output | 656 | 41 best costs, partition p at [p*16 +: 16] |
| best_mv_x | output | 246 | 41 winning horizontal vectors, [p*6 +: 6] |
| best_mv_y | output | 246 | 41 winning vertical vectors, [p*6 +: 6] |
| done | output | 1 | One-cycle pulse when the search results are final |

## Verification
The bench runs a full ±16 search with the current block planted in the reference window. A design that mixed up block order or partition membership would report a nonzero minimum or the wrong vector. A flat window that makes every candidate tie is used to catch a `<=` comparator, which would return the last vector instead of the first. An all-255 against all-0 case pushes the 16×16 sum to 65280, where a narrow adder would wrap. Random candidates with random pixels compare all 41 partitions against an independent rectangle-sum model. A start pulse issued after a search, together with the exact done timing, exposes stale minima and pipeline counting slips.

// File: rtl/vbs_sad_pkg.sv
// Shared constants for the variable block size SAD engine.
// Partition layout in the 41-entry result vector:
//   0 : 16x16, 1..2 : 16x8, 3..4 : 8x16, 5..8 : 8x8,
//   9..16 : 8x4, 17..24 : 4x8, 25..40 : 4x4
package vbs_sad_pkg;
    localparam int SUB_SIDE  = 4;                       // 4x4 primitive
    localparam int SUB_PIX   = SUB_SIDE * SUB_SIDE;     // pixels per block
    localparam int MB_BLOCKS = 16;                      // 4x4 blocks per MB
    localparam int OFF_16X16 = 0;
    localparam int OFF_16X8  = 1;
    localparam int OFF_8X16  = 3;
    localparam int OFF_8X8   = 5;
    localparam int OFF_8X4   = 9;
    localparam int OFF_4X8   = 17;
    localparam int OFF_4X4   = 25;
    localparam int N_PARTS   = 41;
endpackage

// File: rtl/vbs_sad4x4.sv
// 4x4 SAD primitive: one block pair in, one registered SAD out per cycle.
// Assumes unsigned pixels packed row-major, pixel k at [k*PIX_W +: PIX_W].
module vbs_sad4x4
    import vbs_sad_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int SAD_W = PIX_W + 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [SUB_PIX*PIX_W-1:0] cur_px,
    input  logic [SUB_PIX*PIX_W-1:0] ref_px,
    output logic                     out_valid,
    output logic [SAD_W-1:0]         sad
);
    localparam int MAX_SAD = SUB_PIX * ((1 << PIX_W) - 1);

    logic [PIX_W-1:0] absd [SUB_PIX];
    logic [SAD_W-1:0] sum_c;

    // per-pixel absolute difference
    for (genvar g = 0; g < SUB_PIX; g++) begin : g_abs
        logic [PIX_W-1:0] a, b;
        assign a = cur_px[g*PIX_W +: PIX_W];
        assign b = ref_px[g*PIX_W +: PIX_W];
        assign absd[g] = (a > b) ? (a - b) : (b - a);
    end

    // adder chain over the sixteen differences
    always_comb begin
        sum_c = '0;
        for (int k = 0; k < SUB_PIX; k++) sum_c = sum_c + SAD_W'(absd[k]);
    end

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sad       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) sad <= sum_c;
        end
    end

    assert_sad_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(sad) <= MAX_SAD));
    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

// File: rtl/vbs_part_accum.sv
// Collects the sixteen 4x4 SADs of one candidate and, on block 15,
// registers all 41 partition costs with the candidate vector.
// Assumes blocks arrive in raster order and start is not issued mid-candidate.
module vbs_part_accum
    import vbs_sad_pkg::*;
#(
    parameter int SAD_W  = 12,
    parameter int COST_W = 16,
    parameter int MV_W   = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        sad_valid,
    input  logic [SAD_W-1:0]            sad_in,
    input  logic signed [MV_W-1:0]      mv_x_in,
    input  logic signed [MV_W-1:0]      mv_y_in,
    input  logic                        last_in,
    output logic                        cost_valid,
    output logic [N_PARTS*COST_W-1:0]   cost_flat,
    output logic signed [MV_W-1:0]      cost_mv_x,
    output logic signed [MV_W-1:0]      cost_mv_y,
    output logic                        cost_last
);
    localparam int CNT_W = $clog2(MB_BLOCKS);

    logic [CNT_W-1:0]  blk_cnt;
    logic [SAD_W-1:0]  sad_mem [MB_BLOCKS];
    logic [SAD_W-1:0]  sad_all [MB_BLOCKS];
    logic [COST_W-1:0] part_sum [N_PARTS];
    logic              final_blk;

    assign final_blk = sad_valid && (blk_cnt == CNT_W'(MB_BLOCKS - 1));

    // present stored blocks plus the one arriving now
    always_comb begin
        for (int b = 0; b < MB_BLOCKS; b++) sad_all[b] = sad_mem[b];
        sad_all[MB_BLOCKS-1] = sad_in;
    end

    // add each block into every partition that contains it
    always_comb begin
        for (int p = 0; p < N_PARTS; p++) part_sum[p] = '0;
        for (int b = 0; b < MB_BLOCKS; b++) begin
            part_sum[OFF_16X16] = part_sum[OFF_16X16] + COST_W'(sad_all[b]);
            part_sum[OFF_16X8 + b/8] = part_sum[OFF_16X8 + b/8] + COST_W'(sad_all[b]);
            part_sum[OFF_8X16 + (b%4)/2] = part_sum[OFF_8X16 + (b%4)/2] + COST_W'(sad_all[b]);
            part_sum[OFF_8X8 + (b/8)*2 + (b%4)/2] =
                part_sum[OFF_8X8 + (b/8)*2 + (b%4)/2] + COST_W'(sad_all[b]);
            part_sum[OFF_8X4 + 2*((b/8)*2 + (b%4)/2) + (b/4)%2] =
                part_sum[OFF_8X4 + 2*((b/8)*2 + (b%4)/2) + (b/4)%2] + COST_W'(sad_all[b]);
            part_sum[OFF_4X8 + 2*((b/8)*2 + (b%4)/2) + b%2] =
                part_sum[OFF_4X8 + 2*((b/8)*2 + (b%4)/2) + b%2] + COST_W'(sad_all[b]);
            part_sum[OFF_4X4 + b] = part_sum[OFF_4X4 + b] + COST_W'(sad_all[b]);
        end
    end

    // block counter and SAD storage
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            blk_cnt <= '0;
        end else if (sad_valid) begin
            blk_cnt <= blk_cnt + 1'b1;
            sad_mem[blk_cnt] <= sad_in;
        end
    end

    // register the finished candidate's costs
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cost_valid <= 1'b0;
            cost_last  <= 1'b0;
            cost_mv_x  <= '0;
            cost_mv_y  <= '0;
            cost_flat  <= '0;
        end else begin
            cost_valid <= final_blk;
            cost_last  <= final_blk && last_in;
            if (final_blk) begin
                cost_mv_x <= mv_x_in;
                cost_mv_y <= mv_y_in;
                for (int p = 0; p < N_PARTS; p++)
                    cost_flat[p*COST_W +: COST_W] <= part_sum[p];
            end
        end
    end

    assert_cnt_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cost_valid |-> (blk_cnt == '0));
    assert_quad_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cost_valid |-> (cost_flat[0 +: COST_W] ==
            cost_flat[5*COST_W +: COST_W] + cost_flat[6*COST_W +: COST_W] +
            cost_flat[7*COST_W +: COST_W] + cost_flat[8*COST_W +: COST_W]));
    assert_half_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cost_valid |-> (cost_flat[1*COST_W +: COST_W] + cost_flat[2*COST_W +: COST_W] ==
                        cost_flat[3*COST_W +: COST_W] + cost_flat[4*COST_W +: COST_W]));
endmodule

// File: rtl/vbs_best_track.sv
// Per-partition minimum tracker: strict less-than update keeps the first
// candidate on ties. Start or reset loads the maximum cost and a zero vector.
module vbs_best_track
    import vbs_sad_pkg::*;
#(
    parameter int COST_W = 16,
    parameter int MV_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       cost_valid,
    input  logic [N_PARTS*COST_W-1:0]  cost_flat,
    input  logic signed [MV_W-1:0]     cost_mv_x,
    input  logic signed [MV_W-1:0]     cost_mv_y,
    output logic [N_PARTS*COST_W-1:0]  best_cost,
    output logic [N_PARTS*MV_W-1:0]    best_mv_x,
    output logic [N_PARTS*MV_W-1:0]    best_mv_y
);
    localparam logic [COST_W-1:0] COST_MAX = '1;

    for (genvar p = 0; p < N_PARTS; p++) begin : g_part
        logic [COST_W-1:0] cand, best;
        logic              better;
        assign cand   = cost_flat[p*COST_W +: COST_W];
        assign best   = best_cost[p*COST_W +: COST_W];
        assign better = cost_valid && (cand < best);

        // hold the lowest cost and its vector
        always_ff @(posedge clk) begin
            if (!rst_n || start) begin
                best_cost[p*COST_W +: COST_W] <= COST_MAX;
                best_mv_x[p*MV_W +: MV_W]     <= '0;
                best_mv_y[p*MV_W +: MV_W]     <= '0;
            end else if (better) begin
                best_cost[p*COST_W +: COST_W] <= cand;
                best_mv_x[p*MV_W +: MV_W]     <= cost_mv_x;
                best_mv_y[p*MV_W +: MV_W]     <= cost_mv_y;
            end
        end

        assert_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !start |=> (best_cost[p*COST_W +: COST_W] <= $past(best)));
        assert_tie_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!start && cost_valid && cand == best) |=>
                ($stable(best_mv_x[p*MV_W +: MV_W]) && $stable(best_mv_y[p*MV_W +: MV_W])));
        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> (best_cost[p*COST_W +: COST_W] == COST_MAX));
    end
endmodule

// File: rtl/vbs_sad_search.sv
// Top of the variable block size SAD engine: 4x4 SAD stage, partition
// accumulator and per-partition best trackers. Candidate vector and last
// flag travel alongside the SAD pipeline. Latency: done two edges after
// the flagged block is accepted.
module vbs_sad_search
    import vbs_sad_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int MV_W   = 6,
    parameter int COST_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        blk_valid,
    input  logic                        blk_last,
    input  logic signed [MV_W-1:0]      mv_x,
    input  logic signed [MV_W-1:0]      mv_y,
    input  logic [SUB_PIX*PIX_W-1:0]    cur_blk,
    input  logic [SUB_PIX*PIX_W-1:0]    ref_blk,
    output logic [N_PARTS*COST_W-1:0]   best_cost,
    output logic [N_PARTS*MV_W-1:0]     best_mv_x,
    output logic [N_PARTS*MV_W-1:0]     best_mv_y,
    output logic                        done
);
    localparam int SAD_W = PIX_W + $clog2(SUB_PIX);

    logic                       sad_valid;
    logic [SAD_W-1:0]           sad;
    logic signed [MV_W-1:0]     mvx_q, mvy_q;
    logic                       last_q;
    logic                       cost_valid, cost_last;
    logic [N_PARTS*COST_W-1:0]  cost_flat;
    logic signed [MV_W-1:0]     cost_mv_x, cost_mv_y;

    vbs_sad4x4 #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_sad (
        .clk(clk), .rst_n(rst_n), .in_valid(blk_valid),
        .cur_px(cur_blk), .ref_px(ref_blk),
        .out_valid(sad_valid), .sad(sad)
    );

    // side-band registers aligned with the SAD stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mvx_q  <= '0;
            mvy_q  <= '0;
            last_q <= 1'b0;
        end else begin
            last_q <= blk_valid && blk_last;
            if (blk_valid) begin
                mvx_q <= mv_x;
                mvy_q <= mv_y;
            end
        end
    end

    vbs_part_accum #(.SAD_W(SAD_W), .COST_W(COST_W), .MV_W(MV_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sad_valid(sad_valid), .sad_in(sad),
        .mv_x_in(mvx_q), .mv_y_in(mvy_q), .last_in(last_q),
        .cost_valid(cost_valid), .cost_flat(cost_flat),
        .cost_mv_x(cost_mv_x), .cost_mv_y(cost_mv_y), .cost_last(cost_last)
    );

    vbs_best_track #(.COST_W(COST_W), .MV_W(MV_W)) u_best (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cost_valid(cost_valid), .cost_flat(cost_flat),
        .cost_mv_x(cost_mv_x), .cost_mv_y(cost_mv_y),
        .best_cost(best_cost), .best_mv_x(best_mv_x), .best_mv_y(best_mv_y)
    );

    // done pulse, same edge as the final best update
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= !start && cost_valid && cost_last;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cost_valid));
endmodule

// File: tb/tb_vbs_sad_search.sv
module tb_vbs_sad_search;
    localparam int NP = 41;
    localparam int WS = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, blk_valid = 1'b0, blk_last = 1'b0;
    logic signed [5:0] mv_x = '0, mv_y = '0;
    logic [127:0] cur_blk = '0, ref_blk = '0;
    logic [NP*16-1:0] best_cost;
    logic [NP*6-1:0]  best_mv_x, best_mv_y;
    logic done;

    int n_chk = 0, n_bad = 0, cycles = 0;
    int cur_px [256];
    int win [WS*WS];
    int e_cost [NP], e_mvx [NP], e_mvy [NP];

    vbs_sad_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_valid(blk_valid),
        .blk_last(blk_last), .mv_x(mv_x), .mv_y(mv_y),
        .cur_blk(cur_blk), .ref_blk(ref_blk), .best_cost(best_cost),
        .best_mv_x(best_mv_x), .best_mv_y(best_mv_y), .done(done)
    );

    always #4 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic string req_of(int p);
        if (p == 0) return "R3";
        if (p < 5)  return "R4";
        if (p < 25) return "R5";
        return "R1";
    endfunction

    // block-unit rectangle of partition p
    function automatic void rect(int p, output int x0, output int y0, output int w, output int h);
        int k, q;
        if (p == 0) begin x0 = 0; y0 = 0; w = 4; h = 4; end
        else if (p < 3) begin x0 = 0; y0 = 2*(p-1); w = 4; h = 2; end
        else if (p < 5) begin x0 = 2*(p-3); y0 = 0; w = 2; h = 4; end
        else if (p < 9) begin q = p-5; x0 = 2*(q%2); y0 = 2*(q/2); w = 2; h = 2; end
        else if (p < 17) begin k = p-9; q = k/2; x0 = 2*(q%2); y0 = 2*(q/2) + k%2; w = 2; h = 1; end
        else if (p < 25) begin k = p-17; q = k/2; x0 = 2*(q%2) + k%2; y0 = 2*(q/2); w = 1; h = 2; end
        else begin k = p-25; x0 = k%4; y0 = k/4; w = 1; h = 1; end
    endfunction

    function automatic int ref_at(int y, int x, int mvx, int mvy);
        return win[(16 + mvy + y) * WS + 16 + mvx + x];
    endfunction

    function automatic int part_cost(int p, int mvx, int mvy);
        int x0, y0, w, h, s, d;
        rect(p, x0, y0, w, h);
        s = 0;
        for (int y = 4*y0; y < 4*(y0+h); y++)
            for (int x = 4*x0; x < 4*(x0+w); x++) begin
                d = cur_px[y*16+x] - ref_at(y, x, mvx, mvy);
                s += (d < 0) ? -d : d;
            end
        return s;
    endfunction

    function automatic void model_reset();
        for (int p = 0; p < NP; p++) begin e_cost[p] = 65535; e_mvx[p] = 0; e_mvy[p] = 0; end
    endfunction

    function automatic void model_update(int mvx, int mvy);
        int c;
        for (int p = 0; p < NP; p++) begin
            c = part_cost(p, mvx, mvy);
            if (c < e_cost[p]) begin e_cost[p] = c; e_mvx[p] = mvx; e_mvy[p] = mvy; end
        end
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int ac, ax, ay;
        for (int p = 0; p < NP; p++) begin
            ac = int'(best_cost[p*16 +: 16]);
            ax = int'($signed(best_mv_x[p*6 +: 6]));
            ay = int'($signed(best_mv_y[p*6 +: 6]));
            check(ac == e_cost[p], req_of(p), $sformatf("%s cost[%0d]", tag, p), ac, e_cost[p]);
            check(ax == e_mvx[p] && ay == e_mvy[p], "R6/R10",
                  $sformatf("%s mv[%0d] (x*100+y)", tag, p), ax*100+ay, e_mvx[p]*100+e_mvy[p]);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        model_reset();
    endtask

    // send the sixteen blocks of one candidate, back to back (R9)
    task automatic send_cand(int mvx, int mvy, bit last);
        for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            blk_valid = 1'b1;
            blk_last  = last && (b == 15);
            mv_x = 6'(mvx); mv_y = 6'(mvy);
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++) begin
                    cur_blk[(4*i+j)*8 +: 8] = 8'(cur_px[(4*(b/4)+i)*16 + 4*(b%4)+j]);
                    ref_blk[(4*i+j)*8 +: 8] = 8'(ref_at(4*(b/4)+i, 4*(b%4)+j, mvx, mvy));
                end
        end
        model_update(mvx, mvy);
    endtask

    // close the search and check done timing (R8)
    task automatic finish_search(string tag);
        int n = 0;
        @(negedge clk); blk_valid = 1'b0; blk_last = 1'b0;
        do begin @(negedge clk); n++; end while (!done && n < 20);
        check(done && n == 2, "R8", {tag, " done latency"}, n, 2);
        check_all(tag);
        @(negedge clk);
        check(!done, "R8", {tag, " done width"}, int'(done), 0);
    endtask

    initial begin
        int mx, my;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R7)
        model_reset();
        check_all("reset");
        check(!done, "R8", "reset done", int'(done), 0);

        // full search with the current block planted at (5,-7) (R2, R10)
        for (int k = 0; k < WS*WS; k++) win[k] = int'($urandom_range(0, 255));
        for (int k = 0; k < 256; k++) cur_px[k] = int'($urandom_range(0, 255));
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++) win[(16-7+y)*WS + 16+5+x] = cur_px[y*16+x];
        do_start();
        for (int y = -16; y <= 16; y++)
            for (int x = -16; x <= 16; x++)
                send_cand(x, y, (y == 16 && x == 16));
        finish_search("full");
        check(best_cost[15:0] == 16'd0, "R10", "planted cost", int'(best_cost[15:0]), 0);
        check($signed(best_mv_x[5:0]) == 5 && $signed(best_mv_y[5:0]) == -7, "R10",
              "planted mv (x*100+y)", int'($signed(best_mv_x[5:0]))*100 + int'($signed(best_mv_y[5:0])), 493);

        // start clears results (R7)
        do_start();
        check_all("restart");

        // random candidates over random content (R1..R5)
        for (int k = 0; k < WS*WS; k++) win[k] = int'($urandom_range(0, 255));
        for (int k = 0; k < 256; k++) cur_px[k] = int'($urandom_range(0, 255));
        for (int c = 0; c < 40; c++) begin
            mx = int'($urandom_range(0, 32)) - 16;
            my = int'($urandom_range(0, 32)) - 16;
            send_cand(mx, my, c == 39);
        end
        finish_search("random");

        // all candidates tie: first one must remain (R6)
        do_start();
        for (int k = 0; k < WS*WS; k++) win[k] = 100;
        for (int k = 0; k < 256; k++) cur_px[k] = 90;
        send_cand(3, 3, 1'b0);
        send_cand(-16, 16, 1'b0);
        send_cand(0, 0, 1'b0);
        send_cand(16, -16, 1'b1);
        finish_search("tie");
        check($signed(best_mv_x[5:0]) == 3, "R6", "tie first mv_x", int'($signed(best_mv_x[5:0])), 3);

        // largest possible cost: 255 against 0 (R3)
        do_start();
        for (int k = 0; k < WS*WS; k++) win[k] = 0;
        for (int k = 0; k < 256; k++) cur_px[k] = 255;
        send_cand(-16, -16, 1'b1);
        finish_search("max");
        check(best_cost[15:0] == 16'd65280, "R3", "max 16x16", int'(best_cost[15:0]), 65280);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule